// File: doc/BRIEF.md
# Ping-Pong Display Frame Buffer Controller

This block carries decoded picture data from a fast system clock domain to a slower, unrelated display clock domain. On the system side a start command opens a frame at a base address. The writer then fetches words one at a time from memory, each word holding a luma sample and a chroma sample, and fills one bank of a pair of dual-port buffers. One pair holds luma and the other holds chroma, and both pairs always swap together. When the last word of a frame has been taken, a one-cycle frame-done pulse asks for the next base address.

On the display side, a reader drains the bank that is not being written, one word per accepted pixel request, in scan order. When no filled bank is waiting, or output is disabled, it presents black. Pixel data never passes through a synchronizer. Only three levels cross the clock boundary, each through a two-flop chain:
- the enable level, from system to display;
- a write-done toggle, from system to display, meaning a bank is full;
- a read-done toggle, from display to system, meaning a bank has been shown and may be refilled.

The receiving side treats every change of a toggle level as one event. If both banks are full, the writer holds off memory requests until a read-done arrives.

Top module: `pingpong_fb_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start, `mem_req_o`, `frame_done_o` and `pix_vld_o` are 0, and the pixel outputs carry black (luma `BLACK_Y`=16, chroma `BLACK_C`=128).
- R2: A `start_i` pulse loads `base_addr_i`. The accepted requests of a frame then use addresses base+0 up to base+`BANK_WORDS`*`FRAME_BANKS`-1, in increasing order, one per beat.
- R3: A beat is accepted on a system clock edge where `mem_req_o` and `mem_vld_i` are both 1. While `mem_req_o` is 1 and no beat is accepted, `mem_req_o` stays 1 and `mem_addr_o` holds its value on the next cycle.
- R4: `frame_done_o` is 1 for exactly the one system cycle that follows the edge accepting a frame's last beat, and `mem_req_o` is 0 in that cycle. `base_addr_i`, sampled at the edge that ends that cycle, becomes the base of the next frame.
- R5: While both banks are full and no read-done has been received, `mem_req_o` stays 0. With no pixel requests, exactly 2*`BANK_WORDS` beats are accepted after start.
- R6: A display edge with `pix_rdy_i`=1, output enabled and a filled bank waiting consumes one word. In the next display cycle `pix_vld_o`=1, and `pix_luma_o`/`pix_chroma_o` carry that word's two samples. Words appear in the same order in which the beats were accepted.
- R7: In any display cycle that does not follow a consumed word, `pix_vld_o`=0 and the outputs are black. This includes the time before the first write-done arrives.
- R8: A `stop_i` pulse forces `mem_req_o` to 0 from the next system cycle. Once the enable level has crossed, no further words are consumed and only black is shown.
- R9: A read-done frees the oldest full bank, so a stalled writer resumes. The display side never counts more than two filled banks, and the synchronized levels trail their source by exactly two receiving-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | System clock |
| clk_disp_i | input | 1 | Display clock, asynchronous to the system clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| start_i | input | 1 | Start pulse, system domain |
| stop_i | input | 1 | Stop pulse, system domain |
| base_addr_i | input | ADDR_W | Frame base address |
| frame_done_o | output | 1 | One-cycle pulse after a frame's last beat |
| mem_req_o | output | 1 | Memory word request |
| mem_addr_o | output | ADDR_W | Requested word address |
| mem_vld_i | input | 1 | Memory returns the requested word this cycle |
| mem_luma_i | input | PIX_W | Returned luma sample |
| mem_chroma_i | input | PIX_W | Returned chroma sample |
| pix_rdy_i | input | 1 | Display asks for the next pixel |
| pix_vld_o | output | 1 | Pixel output carries buffered data |
| pix_luma_o | output | PIX_W | Luma out, black when not valid |
| pix_chroma_o | output | PIX_W | Chroma out, black when not valid |

## Verification
The system-side results have fixed timing. An accepted beat is visible at the falling edge that follows its rising edge. `frame_done_o` is due in that same half cycle after the last beat. A held request must still be present, with the same address, one cycle later. The bench samples every one of these on the system falling edge, against its own running base and offset.

Display pixels are due one display cycle after the requesting edge and are sampled on the display falling edge. Bank hand-over depends on the crossing delay, which is two to three receiving edges. For that reason the bench checks pixels by order against the list of accepted addresses, not by exact cycle. Checks that depend on the crossing, the stall and the black-after-stop, are made only after a margin of many cycles has passed.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_FILL   = 2'd1,
    WR_RELOAD = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pp_cdc_sync.sv
module pp_cdc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  // R9
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == $past(d_i, 2));
endmodule

// File: rtl/pp_dpram.sv
module pp_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BANK_WORDS  = 16,
  parameter int FRAME_BANKS = 4,
  localparam int BAW        = $clog2(BANK_WORDS),
  localparam int FRAME_WORDS = BANK_WORDS * FRAME_BANKS,
  localparam int FAW        = $clog2(FRAME_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              frame_done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_vld_i,
  input  logic              rd_tgl_i,
  output logic              wr_tgl_o,
  output logic              en_o,
  output logic              ram_we_o,
  output logic              ram_bank_o,
  output logic [BAW-1:0]    ram_addr_o
);
  localparam logic [BAW-1:0] BANK_LAST  = BAW'(BANK_WORDS - 1);
  localparam logic [FAW-1:0] FRAME_LAST = FAW'(FRAME_WORDS - 1);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] base_q;
  logic [BAW-1:0]    wptr_q;
  logic [FAW-1:0]    off_q;
  logic              wsel_q, rsel_q, wr_tgl_q, rd_prev_q;
  logic [1:0]        full_q, full_n;
  logic              beat, bank_end, frame_end, rd_evt;

  always_comb begin
    mem_req_o  = (state_q == WR_FILL) && !full_q[wsel_q];
    beat       = mem_req_o && mem_vld_i;
    bank_end   = beat && (wptr_q == BANK_LAST);
    frame_end  = beat && (off_q == FRAME_LAST);
    rd_evt     = rd_tgl_i ^ rd_prev_q;
    mem_addr_o = base_q + ADDR_W'(off_q);
    full_n     = full_q;
    if (bank_end) full_n[wsel_q] = 1'b1;
    if (rd_evt)   full_n[rsel_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= WR_IDLE;
      base_q    <= '0;
      wptr_q    <= '0;
      off_q     <= '0;
      wsel_q    <= 1'b0;
      rsel_q    <= 1'b0;
      wr_tgl_q  <= 1'b0;
      rd_prev_q <= 1'b0;
      full_q    <= '0;
    end else begin
      rd_prev_q <= rd_tgl_i;
      full_q    <= full_n;
      if (rd_evt) rsel_q <= ~rsel_q;
      if (beat) begin
        wptr_q <= wptr_q + 1'b1;
        off_q  <= off_q + 1'b1;
        if (bank_end) begin
          wptr_q   <= '0;
          wsel_q   <= ~wsel_q;
          wr_tgl_q <= ~wr_tgl_q;
        end
        if (frame_end) off_q <= '0;
      end
      unique case (state_q)
        WR_IDLE: if (start_i) begin
          base_q  <= base_addr_i;
          state_q <= WR_FILL;
        end
        WR_FILL: if (frame_end) state_q <= WR_RELOAD;
        WR_RELOAD: begin
          base_q  <= base_addr_i;
          state_q <= WR_FILL;
        end
        default: state_q <= WR_IDLE;
      endcase
      if (stop_i) begin
        state_q <= WR_IDLE;
        wptr_q  <= '0;
        off_q   <= '0;
      end
    end
  end

  assign frame_done_o = (state_q == WR_RELOAD);
  assign en_o         = (state_q != WR_IDLE);
  assign wr_tgl_o     = wr_tgl_q;
  assign ram_we_o     = beat;
  assign ram_bank_o   = wsel_q;
  assign ram_addr_o   = wptr_q;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_vld_i && !stop_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R4
  fd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  // R4
  fd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_done_o) |-> $past(mem_vld_i));
  // R5
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q == 2'b11) |-> !mem_req_o);
  // R9
  rd_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt |-> full_q[rsel_q]);
endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl #(
  parameter int BANK_WORDS = 16,
  localparam int BAW       = $clog2(BANK_WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           wr_tgl_i,
  input  logic           pix_rdy_i,
  output logic           rd_tgl_o,
  output logic           re_o,
  output logic           rd_bank_o,
  output logic [BAW-1:0] rd_addr_o,
  output logic           vld_o,
  output logic           sel_o
);
  localparam logic [BAW-1:0] BANK_LAST = BAW'(BANK_WORDS - 1);

  logic           wr_prev_q, rsel_q, rd_tgl_q, vld_q, sel_q;
  logic [1:0]     cnt_q, cnt_n;
  logic [BAW-1:0] rptr_q;
  logic           wr_evt, take, last;

  always_comb begin
    wr_evt = wr_tgl_i ^ wr_prev_q;
    take   = pix_rdy_i && en_i && (cnt_q != 2'd0);
    last   = take && (rptr_q == BANK_LAST);
    cnt_n  = cnt_q;
    if (wr_evt && !last)      cnt_n = cnt_q + 2'd1;
    else if (!wr_evt && last) cnt_n = cnt_q - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b0;
      cnt_q     <= '0;
      rsel_q    <= 1'b0;
      rptr_q    <= '0;
      rd_tgl_q  <= 1'b0;
      vld_q     <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      wr_prev_q <= wr_tgl_i;
      cnt_q     <= cnt_n;
      vld_q     <= take;
      if (take) begin
        sel_q  <= rsel_q;
        rptr_q <= rptr_q + 1'b1;
        if (last) begin
          rptr_q   <= '0;
          rsel_q   <= ~rsel_q;
          rd_tgl_q <= ~rd_tgl_q;
        end
      end
    end
  end

  assign rd_tgl_o  = rd_tgl_q;
  assign re_o      = take;
  assign rd_bank_o = rsel_q;
  assign rd_addr_o = rptr_q;
  assign vld_o     = vld_q;
  assign sel_o     = sel_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2);
  // R6
  vld_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(pix_rdy_i));
  // R8
  dis_black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !vld_o);
endmodule

// File: rtl/pingpong_fb_ctrl.sv
module pingpong_fb_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int PIX_W       = 8,
  parameter int BANK_WORDS  = 16,
  parameter int FRAME_BANKS = 4,
  parameter int BLACK_Y     = 16,
  parameter int BLACK_C     = 128,
  localparam int BAW        = $clog2(BANK_WORDS)
) (
  input  logic              clk_sys_i,
  input  logic              clk_disp_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              frame_done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_vld_i,
  input  logic [PIX_W-1:0]  mem_luma_i,
  input  logic [PIX_W-1:0]  mem_chroma_i,
  input  logic              pix_rdy_i,
  output logic              pix_vld_o,
  output logic [PIX_W-1:0]  pix_luma_o,
  output logic [PIX_W-1:0]  pix_chroma_o
);
  logic           en_s, wr_tgl_s, rd_tgl_s;
  logic           en_d, wr_tgl_d, rd_tgl_d;
  logic [1:0]     s2d_q;
  logic           ram_we, ram_bank, re, rd_bank, sel;
  logic [BAW-1:0] ram_addr, rd_addr;
  logic [PIX_W-1:0] luma_q [2];
  logic [PIX_W-1:0] chroma_q [2];

  pp_wr_ctrl #(
    .ADDR_W(ADDR_W), .BANK_WORDS(BANK_WORDS), .FRAME_BANKS(FRAME_BANKS)
  ) u_wr (
    .clk_i(clk_sys_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .base_addr_i(base_addr_i), .frame_done_o(frame_done_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_vld_i(mem_vld_i),
    .rd_tgl_i(rd_tgl_s), .wr_tgl_o(wr_tgl_s), .en_o(en_s),
    .ram_we_o(ram_we), .ram_bank_o(ram_bank), .ram_addr_o(ram_addr)
  );

  pp_cdc_sync #(.WIDTH(2)) u_s2d (
    .clk_i(clk_disp_i), .rst_ni(rst_ni), .d_i({en_s, wr_tgl_s}), .q_o(s2d_q)
  );
  assign {en_d, wr_tgl_d} = s2d_q;

  pp_cdc_sync #(.WIDTH(1)) u_d2s (
    .clk_i(clk_sys_i), .rst_ni(rst_ni), .d_i(rd_tgl_d), .q_o(rd_tgl_s)
  );

  pp_rd_ctrl #(.BANK_WORDS(BANK_WORDS)) u_rd (
    .clk_i(clk_disp_i), .rst_ni(rst_ni), .en_i(en_d), .wr_tgl_i(wr_tgl_d),
    .pix_rdy_i(pix_rdy_i), .rd_tgl_o(rd_tgl_d), .re_o(re),
    .rd_bank_o(rd_bank), .rd_addr_o(rd_addr), .vld_o(pix_vld_o), .sel_o(sel)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_dpram #(.DW(PIX_W), .DEPTH(BANK_WORDS)) u_luma (
      .wclk_i(clk_sys_i), .we_i(ram_we && (ram_bank == 1'(b))),
      .waddr_i(ram_addr), .wdata_i(mem_luma_i),
      .rclk_i(clk_disp_i), .re_i(re && (rd_bank == 1'(b))),
      .raddr_i(rd_addr), .rdata_o(luma_q[b])
    );
    pp_dpram #(.DW(PIX_W), .DEPTH(BANK_WORDS)) u_chroma (
      .wclk_i(clk_sys_i), .we_i(ram_we && (ram_bank == 1'(b))),
      .waddr_i(ram_addr), .wdata_i(mem_chroma_i),
      .rclk_i(clk_disp_i), .re_i(re && (rd_bank == 1'(b))),
      .raddr_i(rd_addr), .rdata_o(chroma_q[b])
    );
  end

  assign pix_luma_o   = pix_vld_o ? luma_q[sel]   : PIX_W'(BLACK_Y);
  assign pix_chroma_o = pix_vld_o ? chroma_q[sel] : PIX_W'(BLACK_C);
endmodule

// File: tb/pingpong_fb_ctrl_tb_top.sv
`timescale 1ns/100ps
module pingpong_fb_ctrl_tb_top;
  localparam int BW = 16;
  localparam int FW = 64;

  logic clk_s = 1'b0, clk_d = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, mem_vld_i = 1'b0, pix_rdy_i = 1'b0;
  logic [15:0] base_addr_i = '0;
  logic [7:0]  mem_luma_i = '0, mem_chroma_i = '0;
  logic frame_done_o, mem_req_o, pix_vld_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  pix_luma_o, pix_chroma_o;

  always #2   clk_s = ~clk_s;
  always #4.5 clk_d = ~clk_d;

  pingpong_fb_ctrl dut_i (
    .clk_sys_i(clk_s), .clk_disp_i(clk_d), .rst_ni(rst_ni),
    .start_i(start_i), .stop_i(stop_i), .base_addr_i(base_addr_i),
    .frame_done_o(frame_done_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_vld_i(mem_vld_i), .mem_luma_i(mem_luma_i), .mem_chroma_i(mem_chroma_i),
    .pix_rdy_i(pix_rdy_i), .pix_vld_o(pix_vld_o),
    .pix_luma_o(pix_luma_o), .pix_chroma_o(pix_chroma_o)
  );

  int n_chk = 0, n_fail = 0;
  int beats = 0, disp_n = 0, boff = 0;
  int disp_mode = 0;
  bit resp_on = 1'b0, stopping = 1'b0, strict_blk = 1'b0, running = 1'b0;
  logic [15:0] cur_base = '0;
  logic [15:0] acc_a [0:1023];

  function automatic logic [7:0] f_luma(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] f_chroma(input logic [15:0] a);
    return a[7:0] + 8'd77;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // system side: memory model and address / frame-done checks
  initial begin
    logic had_req = 1'b0;
    logic [15:0] addr_prev = '0;
    forever begin
      @(negedge clk_s);
      if (running) begin
        if (mem_vld_i) begin
          chk(addr_prev == cur_base + 16'(boff), "R2 beat address", addr_prev, cur_base + 16'(boff));
          if (beats < 1024) acc_a[beats] = addr_prev;
          beats++;
          boff++;
          if (boff == FW) begin
            boff = 0;
            chk(frame_done_o && !mem_req_o, "R4 frame_done after last beat",
                {frame_done_o, mem_req_o}, 2'b10);
            cur_base = 16'($urandom_range(0, 16'h7FFF));
            base_addr_i = cur_base;
          end else begin
            chk(!frame_done_o, "R4 no frame_done mid-frame", frame_done_o, 0);
          end
        end else if (had_req && !stopping) begin
          chk(mem_req_o && mem_addr_o == addr_prev, "R3 request held",
              mem_addr_o, addr_prev);
        end
      end
      had_req   = mem_req_o;
      addr_prev = mem_addr_o;
      if (resp_on && mem_req_o && ($urandom_range(0, 2) != 0)) begin
        mem_vld_i    = 1'b1;
        mem_luma_i   = f_luma(mem_addr_o);
        mem_chroma_i = f_chroma(mem_addr_o);
      end else begin
        mem_vld_i = 1'b0;
      end
    end
  end

  // display side: pixel scoreboard and request driver
  initial begin
    forever begin
      @(negedge clk_d);
      if (rst_ni) begin
        if (pix_vld_o) begin
          if (disp_n < beats && disp_n < 1024) begin
            chk(pix_luma_o == f_luma(acc_a[disp_n]), "R6 luma order",
                pix_luma_o, f_luma(acc_a[disp_n]));
            chk(pix_chroma_o == f_chroma(acc_a[disp_n]), "R6 chroma order",
                pix_chroma_o, f_chroma(acc_a[disp_n]));
          end else begin
            chk(1'b0, "R6 pixel without accepted beat", disp_n, beats);
          end
          disp_n++;
        end else begin
          chk(pix_luma_o == 8'd16 && pix_chroma_o == 8'd128, "R7 black when idle",
              {pix_luma_o, pix_chroma_o}, 16'h1080);
        end
        if (strict_blk)
          chk(!pix_vld_o, "R8 no pixels after stop", pix_vld_o, 0);
      end
      case (disp_mode)
        0: pix_rdy_i = 1'b0;
        1: pix_rdy_i = ($urandom_range(0, 3) != 0);
        default: pix_rdy_i = 1'b1;
      endcase
    end
  end

  initial begin
    repeat (100000) @(posedge clk_s);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1234_5678);
    #43 rst_ni = 1'b1;
    repeat (3) @(negedge clk_s);
    // R1: reset state
    chk(!mem_req_o && !frame_done_o, "R1 idle after reset", {mem_req_o, frame_done_o}, 0);
    chk(!pix_vld_o && pix_luma_o == 8'd16 && pix_chroma_o == 8'd128, "R1 black after reset",
        {pix_vld_o, pix_luma_o, pix_chroma_o}, 17'h01080);
    repeat (20) @(negedge clk_s);
    chk(!mem_req_o, "R1 no request without start", mem_req_o, 0);

    // start frame, pixel requests high before any write-done (R7)
    cur_base    = 16'h0100;
    base_addr_i = cur_base;
    running     = 1'b1;
    resp_on     = 1'b1;
    disp_mode   = 2;
    start_i     = 1'b1;
    @(negedge clk_s);
    start_i = 1'b0;
    @(negedge clk_d);
    @(negedge clk_d);
    chk(!pix_vld_o && pix_luma_o == 8'd16, "R7 black before first write-done",
        {pix_vld_o, pix_luma_o}, 9'h010);
    disp_mode = 0;

    // R5: stall with both banks full
    for (int i = 0; i < 2000 && beats < 2 * BW; i++) @(negedge clk_s);
    repeat (150) @(negedge clk_s);
    chk(beats == 2 * BW, "R5 beats before stall", beats, 2 * BW);
    chk(!mem_req_o, "R5 request held off while full", mem_req_o, 0);

    // R9 / R6: resume with random pixel demand over several frames
    disp_mode = 1;
    for (int i = 0; i < 60000 && disp_n < 4 * FW; i++) @(negedge clk_s);
    chk(beats > 2 * BW, "R9 writer resumed after read-done", beats, 2 * BW + 1);
    chk(disp_n >= 4 * FW, "R6 four frames displayed", disp_n, 4 * FW);

    // R8: stop
    resp_on  = 1'b0;
    stopping = 1'b1;
    repeat (2) @(negedge clk_s);
    stop_i = 1'b1;
    @(negedge clk_s);
    stop_i = 1'b0;
    @(negedge clk_s);
    chk(!mem_req_o, "R8 request dropped after stop", mem_req_o, 0);
    disp_mode = 2;
    repeat (10) @(negedge clk_d);
    strict_blk = 1'b1;
    repeat (20) @(negedge clk_d);
    strict_blk = 1'b0;
    chk(!mem_req_o, "R8 request stays low", mem_req_o, 0);
    summary();
  end
endmodule